// File: doc/BRIEF.md
# Calibration ROM Readback Sequencer

This block copies a tuner's factory calibration bytes into local registers once the chip comes out of reset. The ROM cannot be read directly. For each entry the sequencer first writes the entry number into a ROM-address register. It then waits a programmable number of clock cycles so the ROM byte can move into a readback register, and then reads that register. Entries 0 to 8 are walked in ascending order. Entry 0 carries a 3-bit trim for the overload detector in its top three bits. Entries 1 to 8 carry the eight slope and intercept coefficients of the tracking filters.

When the last entry has been read, the sequencer writes the trim back into the tuner's overload-detector register and raises `done_o`. The coefficients and the trim stay on parallel outputs for the channel-tuning logic to use. If any bus transaction reports an error, or is not answered within a fixed number of cycles, the sequence stops and `err_o` is raised instead of `done_o`. A one-cycle `start_i` pulse clears the stored values and runs the whole sequence again.

The bus is a simple master port. A request (`bus_wr_o` or `bus_rd_o`) is held with constant address and data until the cycle in which `bus_rdy_i` is high. `bus_err_i` is sampled in that same cycle.

Top module: `cal_rom_reader`

## Requirements
- R1: While `rst_n` is low, no bus request is issued and `done_o`, `err_o`, `trim_o` and `coef_o` are zero. After reset is released the sequence starts without any start pulse.
- R2: Entry n (n = 0 to 8, ascending) is fetched as a write of value n (zero-extended) to address 0x0C, followed by a read of address 0x0D. No other requests are issued between these pairs.
- R3: The read of an entry is first presented exactly `cfg_wait_i` + 1 cycles after the cycle in which its address write was accepted. A wait of 0 gives the next cycle.
- R4: `trim_o` equals bits 7:5 of the byte read for entry 0.
- R5: Slot k of `coef_o` (bits 8k+7:8k, k = 0 to 7) holds the byte read for entry k+1, in this order: VHF series intercept, VHF series slope, VHF parallel intercept, VHF parallel slope, UHF series intercept, UHF series slope, UHF parallel intercept, UHF parallel slope.
- R6: After entry 8 is read, exactly one write of `trim_o` (zero-extended) to address 0x0E is issued. `done_o` rises in the cycle after that write is accepted.
- R7: A transaction that completes with `bus_err_i` high ends the sequence. `err_o` rises, `done_o` stays low, and no further request is issued (in particular no trim write).
- R8: A request that has not seen `bus_rdy_i` in its first 16 cycles (`TMO_CYC`) raises `err_o` in the next cycle. A ready in the 16th cycle is still accepted.
- R9: A `start_i` pulse drops any pending request. In the next cycle `done_o`, `err_o`, `trim_o` and `coef_o` are zero, and the sequence restarts from entry 0.
- R10: Write and read requests are never asserted together. A pending request keeps its address and write data stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Restart pulse |
| cfg_wait_i | input | 8 | Cycles to wait between address write and data read |
| bus_wr_o | output | 1 | Write request |
| bus_rd_o | output | 1 | Read request |
| bus_addr_o | output | 8 | Register address |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data, valid with ready |
| bus_rdy_i | input | 1 | Transaction completes this cycle |
| bus_err_i | input | 1 | Completing transaction failed |
| coef_o | output | 64 | Eight stored coefficient bytes |
| trim_o | output | 3 | Stored overload-detector trim |
| done_o | output | 1 | Sequence finished successfully |
| err_o | output | 1 | Sequence aborted |

## Verification
Every result is due at a fixed cycle distance from the stimulus that causes it:
- Each data read appears `cfg_wait_i` + 1 cycles after its address write is accepted.
- `done_o` appears one cycle after the trim write is accepted.
- `err_o` appears `TMO_CYC` cycles after an unanswered request is first seen.
- The cleared outputs appear one cycle after a start pulse.

The bench's bus responder numbers every falling edge. It logs the edge at which it gave ready and the edge at which each request or flag first appears, and compares the differences with these distances. The bench drives inputs and reads outputs only at falling edges, so every value it samples has settled one full half-period after the rising edge that produced it.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic [2:0] {
        ST_LAUNCH,
        ST_ADDR,
        ST_WAIT,
        ST_READ,
        ST_TRIM,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

endpackage

// File: rtl/cal_cycle_counter.sv
module cal_cycle_counter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr)
            cnt_d = '0;
        else if (cnt_q == '1)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/cal_coef_bank.sv
module cal_coef_bank #(
    parameter int N  = 8,
    parameter int DW = 8,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    output logic [N*DW-1:0] coef_o
);

    for (genvar k = 0; k < N; k++) begin : g_slot
        logic [DW-1:0] slot_d, slot_q;

        always_comb begin
            if (clr)
                slot_d = '0;
            else if (we && (widx == IW'(k)))
                slot_d = wdata;
            else
                slot_d = slot_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign coef_o[k*DW +: DW] = slot_q;
    end

endmodule

// File: rtl/cal_rom_reader.sv
module cal_rom_reader
    import cal_pkg::*;
#(
    parameter int BUS_AW   = 8,
    parameter int BUS_DW   = 8,
    parameter int ROM_AW   = 4,
    parameter int COEF_N   = 8,
    parameter int TRIM_W   = 3,
    parameter int TRIM_LSB = 5,
    parameter int WAIT_W   = 8,
    parameter int TMO_CYC  = 16,
    parameter logic [BUS_AW-1:0] REG_ROM_ADDR = 'h0C,
    parameter logic [BUS_AW-1:0] REG_ROM_DATA = 'h0D,
    parameter logic [BUS_AW-1:0] REG_TRIM     = 'h0E
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [WAIT_W-1:0]        cfg_wait_i,
    output logic                     bus_wr_o,
    output logic                     bus_rd_o,
    output logic [BUS_AW-1:0]        bus_addr_o,
    output logic [BUS_DW-1:0]        bus_wdata_o,
    input  logic [BUS_DW-1:0]        bus_rdata_i,
    input  logic                     bus_rdy_i,
    input  logic                     bus_err_i,
    output logic [COEF_N*BUS_DW-1:0] coef_o,
    output logic [TRIM_W-1:0]        trim_o,
    output logic                     done_o,
    output logic                     err_o
);

    localparam int LAST_ENTRY = COEF_N;
    localparam int TMO_W      = $clog2(TMO_CYC + 1);
    localparam int CNT_W      = ((WAIT_W > TMO_W) ? WAIT_W : TMO_W) + 1;

    typedef struct packed {
        seq_state_e          st;
        logic [ROM_AW-1:0]   idx;
        logic [TRIM_W-1:0]   trim;
    } seq_t;

    seq_t s_d, s_q;

    logic [CNT_W-1:0]  cnt_q;
    logic              cnt_clr;
    logic              tmo_hit;
    logic              wait_met;
    logic              bank_we;
    logic [ROM_AW-1:0] slot_idx;

    assign tmo_hit  = (cnt_q == CNT_W'(TMO_CYC - 1));
    assign wait_met = ((cnt_q + CNT_W'(1)) >= CNT_W'(cfg_wait_i));
    assign slot_idx = s_q.idx - ROM_AW'(1);

    // next-state computation
    always_comb begin
        s_d     = s_q;
        bank_we = 1'b0;
        unique case (s_q.st)
            ST_LAUNCH: begin
                s_d.idx = '0;
                s_d.st  = ST_ADDR;
            end
            ST_ADDR: begin
                if (bus_rdy_i) begin
                    if (bus_err_i)
                        s_d.st = ST_FAIL;
                    else if (cfg_wait_i == '0)
                        s_d.st = ST_READ;
                    else
                        s_d.st = ST_WAIT;
                end else if (tmo_hit) begin
                    s_d.st = ST_FAIL;
                end
            end
            ST_WAIT: begin
                if (wait_met) s_d.st = ST_READ;
            end
            ST_READ: begin
                if (bus_rdy_i) begin
                    if (bus_err_i) begin
                        s_d.st = ST_FAIL;
                    end else begin
                        if (s_q.idx == '0)
                            s_d.trim = bus_rdata_i[TRIM_LSB +: TRIM_W];
                        else
                            bank_we = 1'b1;
                        if (s_q.idx == ROM_AW'(LAST_ENTRY)) begin
                            s_d.st = ST_TRIM;
                        end else begin
                            s_d.idx = s_q.idx + ROM_AW'(1);
                            s_d.st  = ST_ADDR;
                        end
                    end
                end else if (tmo_hit) begin
                    s_d.st = ST_FAIL;
                end
            end
            ST_TRIM: begin
                if (bus_rdy_i)
                    s_d.st = bus_err_i ? ST_FAIL : ST_DONE;
                else if (tmo_hit)
                    s_d.st = ST_FAIL;
            end
            default: ;
        endcase

        if (start_i) begin
            s_d.st   = ST_LAUNCH;
            s_d.idx  = '0;
            s_d.trim = '0;
            bank_we  = 1'b0;
        end
    end

    assign cnt_clr = (s_d.st != s_q.st);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_LAUNCH, idx: '0, trim: '0};
        else        s_q <= s_d;
    end

    cal_cycle_counter #(
        .W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt_o (cnt_q)
    );

    cal_coef_bank #(
        .N  (COEF_N),
        .DW (BUS_DW),
        .IW (ROM_AW)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start_i),
        .we     (bank_we),
        .widx   (slot_idx),
        .wdata  (bus_rdata_i),
        .coef_o (coef_o)
    );

    // bus request decode
    always_comb begin
        bus_wr_o    = 1'b0;
        bus_rd_o    = 1'b0;
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        unique case (s_q.st)
            ST_ADDR: begin
                bus_wr_o    = 1'b1;
                bus_addr_o  = REG_ROM_ADDR;
                bus_wdata_o = BUS_DW'(s_q.idx);
            end
            ST_READ: begin
                bus_rd_o    = 1'b1;
                bus_addr_o  = REG_ROM_DATA;
            end
            ST_TRIM: begin
                bus_wr_o    = 1'b1;
                bus_addr_o  = REG_TRIM;
                bus_wdata_o = BUS_DW'(s_q.trim);
            end
            default: ;
        endcase
    end

    assign trim_o = s_q.trim;
    assign done_o = (s_q.st == ST_DONE);
    assign err_o  = (s_q.st == ST_FAIL);

endmodule

// File: rtl/cal_rom_reader_chk.sv
module cal_rom_reader_chk #(
    parameter int BUS_AW  = 8,
    parameter int BUS_DW  = 8,
    parameter int COEF_N  = 8,
    parameter int TRIM_W  = 3,
    parameter int TMO_CYC = 16,
    parameter logic [BUS_AW-1:0] REG_TRIM = 'h0E
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_i,
    input logic                     bus_wr_o,
    input logic                     bus_rd_o,
    input logic [BUS_AW-1:0]        bus_addr_o,
    input logic [BUS_DW-1:0]        bus_wdata_o,
    input logic                     bus_rdy_i,
    input logic                     bus_err_i,
    input logic [COEF_N*BUS_DW-1:0] coef_o,
    input logic [TRIM_W-1:0]        trim_o,
    input logic                     done_o,
    input logic                     err_o
);

    localparam int PW = $clog2(TMO_CYC + 2) + 1;

    logic [PW-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= '0;
        else if (start_i || !(bus_wr_o || bus_rd_o) || bus_rdy_i)
            pend_q <= '0;
        else if (pend_q != '1)
            pend_q <= pend_q + PW'(1);
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (!bus_wr_o && !bus_rd_o));

    // R10
    one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_o && bus_rd_o));

    // R10
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr_o || bus_rd_o) && !bus_rdy_i && !start_i) |=>
        (((bus_wr_o == $past(bus_wr_o)) && (bus_rd_o == $past(bus_rd_o)) &&
          $stable(bus_addr_o) && $stable(bus_wdata_o)) || err_o));

    // R7
    err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr_o || bus_rd_o) && bus_rdy_i && bus_err_i && !start_i) |=> err_o);

    // R7
    fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> (err_o && !done_o && !bus_wr_o && !bus_rd_o));

    // R6
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(bus_wr_o && bus_rdy_i && !bus_err_i && (bus_addr_o == REG_TRIM)));

    // R6
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    // R9
    restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_o && !err_o && (coef_o == '0) && (trim_o == '0)));

    // R8
    tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= PW'(TMO_CYC));

    // R8
    tmo_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == PW'(TMO_CYC)) |-> err_o);

endmodule

bind cal_rom_reader cal_rom_reader_chk #(
    .BUS_AW   (BUS_AW),
    .BUS_DW   (BUS_DW),
    .COEF_N   (COEF_N),
    .TRIM_W   (TRIM_W),
    .TMO_CYC  (TMO_CYC),
    .REG_TRIM (REG_TRIM)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .bus_wr_o    (bus_wr_o),
    .bus_rd_o    (bus_rd_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rdy_i   (bus_rdy_i),
    .bus_err_i   (bus_err_i),
    .coef_o      (coef_o),
    .trim_o      (trim_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/cal_rom_reader_tb.sv
`timescale 1ns/1ps
module cal_rom_reader_tb_top;

    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cfg_wait = 8'd2;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_addr, bus_wdata;
    logic [7:0]  bus_rdata = 8'h00;
    logic        bus_rdy = 1'b0;
    logic        bus_err = 1'b0;
    logic [63:0] coef;
    logic [2:0]  trim;
    logic        done, err;

    always #10 clk = ~clk;

    cal_rom_reader #(.TMO_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_wait_i(cfg_wait),
        .bus_wr_o(bus_wr), .bus_rd_o(bus_rd), .bus_addr_o(bus_addr),
        .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_rdy_i(bus_rdy),
        .bus_err_i(bus_err), .coef_o(coef), .trim_o(trim), .done_o(done), .err_o(err)
    );

    // test controls, written only by the main initial block
    logic [7:0] rom [9];
    int  lat = 0;
    int  err_entry = 99;
    bit  start_tog = 0;
    bit  clr_tog = 0;

    // responder state, written only by the responder
    bit  start_seen = 0, clr_seen = 0, in_req = 0, sv_wr = 0;
    int  cyc = 0, wcnt = 0, rdy_cyc = 0, last_wacc = 0;
    int  log_n = 0, gap_n = 0, first_req = 0, done_cyc = 0, err_cyc = 0;
    logic [7:0] sv_addr, sv_wdata;
    logic [3:0] rom_sel = 4'd0;
    bit  rec_wr [32];
    logic [7:0] rec_addr [32];
    logic [7:0] rec_wdata [32];
    int  rec_cyc [32];
    int  gaps [16];

    int total = 0, bad = 0;

    localparam logic [23:0] RUNS [5] = '{
        24'h00_00_5B, 24'h01_00_C3, 24'h04_02_17, 24'h09_05_E8, 24'h02_0F_71
    };

    // bus responder: one process, falling edge
    always @(negedge clk) begin
        cyc++;
        if (clr_tog != clr_seen) begin
            clr_seen = clr_tog;
            log_n = 0; gap_n = 0; first_req = 0; done_cyc = 0; err_cyc = 0;
        end
        if (bus_rdy) begin
            if (!start && log_n < 32) begin
                rec_wr[log_n] = sv_wr; rec_addr[log_n] = sv_addr;
                rec_wdata[log_n] = sv_wdata; rec_cyc[log_n] = rdy_cyc;
                log_n++;
                if (sv_wr && sv_addr == 8'h0C) begin
                    rom_sel = sv_wdata[3:0];
                    last_wacc = rdy_cyc;
                end
            end
            bus_rdy = 1'b0; bus_err = 1'b0; wcnt = 0; in_req = 0;
        end
        if (start_tog != start_seen) begin
            start_seen = start_tog; start = 1'b1; wcnt = 0; in_req = 0;
        end else begin
            start = 1'b0;
        end
        if ((bus_wr || bus_rd) && !start) begin
            if (!in_req) begin
                in_req = 1;
                if (first_req == 0) first_req = cyc;
                if (bus_rd && gap_n < 16) begin
                    gaps[gap_n] = cyc - last_wacc;
                    gap_n++;
                end
            end
            if (wcnt == lat) begin
                bus_rdy = 1'b1;
                bus_rdata = (rom_sel < 4'd9) ? rom[rom_sel] : 8'h00;
                bus_err = bus_rd && (err_entry == int'(rom_sel));
                sv_wr = bus_wr; sv_addr = bus_addr; sv_wdata = bus_wdata;
                rdy_cyc = cyc;
            end else begin
                wcnt++;
            end
        end
        if (done && done_cyc == 0) done_cyc = cyc;
        if (err && err_cyc == 0) err_cyc = cyc;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic fill_rom(input int seed);
        for (int i = 0; i < 9; i++) rom[i] = 8'((seed * (i + 3) + i * 29) ^ (i << 4));
    endtask

    // restart the sequence; checks the cleared state one cycle after the pulse
    task automatic kick();
        @(negedge clk); #1;
        start_tog = ~start_tog;
        @(negedge clk);
        @(negedge clk); #1;
        chk(!done && !err, "R9 flags cleared", {done, err}, 0);
        chk(coef == 64'd0 && trim == 3'd0, "R9 values cleared", coef, 0);
        clr_tog = ~clr_tog;
    endtask

    task automatic wait_end();
        bit fin = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done || err) begin fin = 1; break; end
        end
        @(negedge clk); #1;
        chk(fin, "sequence ended", fin, 1);
    endtask

    task automatic check_success(input int w);
        int mis = 0;
        int gmis = 0;
        chk(done && !err, "R6 done flag", {done, err}, 2);
        chk(log_n == 19, "R2 transaction count", log_n, 19);
        for (int i = 0; i < 9; i++) begin
            if (!(rec_wr[2*i] && rec_addr[2*i] == 8'h0C && rec_wdata[2*i] == 8'(i))) mis++;
            if (!(!rec_wr[2*i+1] && rec_addr[2*i+1] == 8'h0D)) mis++;
        end
        chk(mis == 0, "R2 entry order", mis, 0);
        for (int i = 0; i < 9; i++) if (gaps[i] != w + 1) gmis++;
        chk(gap_n == 9 && gmis == 0, "R3 wait gap", gaps[0], w + 1);
        chk(trim == rom[0][7:5], "R4 trim", trim, rom[0][7:5]);
        for (int k = 0; k < 8; k++)
            chk(coef[8*k +: 8] == rom[k+1], "R5 coef slot", coef[8*k +: 8], rom[k+1]);
        chk(rec_wr[18] && rec_addr[18] == 8'h0E && rec_wdata[18] == {5'd0, rom[0][7:5]},
            "R6 trim write", rec_wdata[18], {5'd0, rom[0][7:5]});
        chk(done_cyc == rec_cyc[18] + 1, "R6 done timing", done_cyc - rec_cyc[18], 1);
    endtask

    initial begin
        #3_000_000;
        bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        fill_rom(8'h3D); lat = 1; cfg_wait = 8'd2;
        repeat (3) @(negedge clk);
        #1;
        chk(!bus_wr && !bus_rd, "R1 no request in reset", {bus_wr, bus_rd}, 0);
        chk(!done && !err && coef == 64'd0 && trim == 3'd0, "R1 outputs zero", coef, 0);
        clr_tog = ~clr_tog;
        @(negedge clk); #1;
        rst_n = 1'b1;
        wait_end();
        check_success(2);   // R1 autostart

        // table of runs: wait, latency, rom seed
        for (int r = 0; r < 5; r++) begin
            cfg_wait = RUNS[r][23:16];
            lat = int'(RUNS[r][15:8]);
            err_entry = 99;
            fill_rom(int'(RUNS[r][7:0]));
            kick();
            wait_end();
            check_success(int'(RUNS[r][23:16]));
        end

        // R7: error reported on read of entry 3
        cfg_wait = 8'd1; lat = 1; err_entry = 3; fill_rom(8'h92);
        kick();
        wait_end();
        chk(err && !done, "R7 error flag", {done, err}, 1);
        begin
            int tw = 0;
            for (int i = 0; i < log_n; i++) if (rec_addr[i] == 8'h0E) tw++;
            chk(tw == 0, "R7 no trim write", tw, 0);
        end
        chk(coef[7:0] == rom[1] && coef[15:8] == rom[2], "R5 slots before error", coef[15:0], {rom[2], rom[1]});
        repeat (20) @(negedge clk);
        #1;
        chk(!bus_wr && !bus_rd && err, "R7 stays idle", {bus_wr, bus_rd, err}, 1);

        // R8: unanswered request
        cfg_wait = 8'd2; lat = TMO; err_entry = 99;
        kick();
        wait_end();
        chk(err && !done, "R8 timeout flag", {done, err}, 1);
        chk(err_cyc - first_req == TMO, "R8 timeout timing", err_cyc - first_req, TMO);
        chk(log_n == 0, "R8 nothing accepted", log_n, 0);

        // R9: restart in the middle of a sequence
        cfg_wait = 8'd3; lat = 2; fill_rom(8'h4E);
        kick();
        repeat (60) @(negedge clk);
        #1;
        chk(!done && coef[7:0] == rom[1], "R9 partial before restart", coef[7:0], rom[1]);
        fill_rom(8'hB6);
        kick();
        wait_end();
        check_success(3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule